// File: doc/BRIEF.md
# Six-Control-Bit Combinational ALU

This block is a two-operand arithmetic and logic unit with no storage. Six independent control bits are applied in a fixed chain. Each operand may be forced to zero and then bitwise inverted. The two conditioned operands are then either added or bitwise ANDed. The selected value may finally be inverted.

That small set of primitives is enough to produce constants, pass-through, NOT, two's-complement negation, increment, decrement, add, subtract, AND and OR. No opcode decoder is needed. Besides the result, the block drives a zero flag and a sign flag for the conditional-branch logic that follows it.

The block sits between the register file and the write-back bus of a small accumulator-style datapath.

Top module: `alu6_core`

## Requirements
- R1: `op[5]` zeroes X, and `op[4]` then inverts every bit of the value from that zeroing step. With both set, the X operand seen by the function stage is all ones.
- R2: `op[3]` zeroes Y, and `op[2]` then inverts every bit of the value from that zeroing step, in the same order as for X.
- R3: When `op[1]` is 1 the function stage gives the sum of the conditioned operands modulo 2^WIDTH, with the carry out of the top bit dropped (0xFFFF plus 1 gives 0x0000). When `op[1]` is 0 it gives their bitwise AND.
- R4: `op[0]` set to 1 inverts every bit of the function-stage value before it reaches `res`.
- R5: Code 000010 gives X+Y (3 and 5 give 8), and code 110111 gives Y+1 (Y=5 gives 6).
- R6: `zr` is 1 exactly when `res` is 0x0000, and `ng` equals bit WIDTH-1 of `res`.
- R7: The 18 standard codes map to the following operations (code as `op[5:0]`):
  - 101010 gives 0; 111111 gives 1; 111010 gives -1.
  - 001100 gives X; 110000 gives Y; 001101 gives ~X; 110001 gives ~Y.
  - 001111 gives -X; 110011 gives -Y.
  - 011111 gives X+1; 110111 gives Y+1; 001110 gives X-1; 110010 gives Y-1.
  - 000010 gives X+Y; 010011 gives X-Y; 000111 gives Y-X.
  - 000000 gives X&Y; 010101 gives X|Y.
- R8: All outputs are pure combinational functions of the present inputs: no clock, no state, and no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 6 | Control bits: [5] zero X, [4] invert X, [3] zero Y, [2] invert Y, [1] add/AND select, [0] invert result |
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| res | output | 16 | Result |
| zr | output | 1 | Result-is-zero flag |
| ng | output | 1 | Result sign bit |

## Verification
Every result and flag is due in the same cycle its inputs are applied, since no register lies on any path. The bench drives a new code and new operands just after a rising edge. It compares `res`, `zr` and `ng` with a behavioural model at the following falling edge, half a period later, once the logic has settled. Because each vector stands alone, any state kept inside the design would show up as a miscompare on a later vector.

// File: rtl/alu6_pkg.sv
package alu6_pkg;
    localparam int unsigned OP_BITS = 6;

    typedef struct packed {
        logic zero_x;
        logic inv_x;
        logic zero_y;
        logic inv_y;
        logic sel_add;
        logic inv_out;
    } alu_op_t;
endpackage

// File: rtl/alu6_cond.sv
// Operand conditioning: optional clear, then optional inversion.
module alu6_cond #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] din,
    input  logic             clr,
    input  logic             inv,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] cleared;

    always_comb begin
        cleared = clr ? '0 : din;
        dout    = inv ? ~cleared : cleared;
    end
endmodule

// File: rtl/alu6_func.sv
// Function stage: sum or AND of the conditioned operands, optional output inversion.
module alu6_func #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sel_add,
    input  logic             inv_out,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] sum_v;
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] pick;

    always_comb begin
        sum_v = a + b;      // carry out of the top bit is dropped
        and_v = a & b;
        pick  = sel_add ? sum_v : and_v;
        y     = inv_out ? ~pick : pick;
    end
endmodule

// File: rtl/alu6_flags.sv
// Status flags for the branch logic downstream.
module alu6_flags #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] val,
    output logic             is_zero,
    output logic             is_neg
);
    always_comb begin
        is_zero = ~|val;
        is_neg  = val[WIDTH-1];
    end
endmodule

// File: rtl/alu6_core.sv
module alu6_core
    import alu6_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [OP_BITS-1:0] op,
    input  logic [WIDTH-1:0]   x,
    input  logic [WIDTH-1:0]   y,
    output logic [WIDTH-1:0]   res,
    output logic               zr,
    output logic               ng
);
    localparam int unsigned N_OPND = 2;

    alu_op_t          ctl;
    logic [WIDTH-1:0] opnd_in   [N_OPND];
    logic [WIDTH-1:0] opnd_out  [N_OPND];
    logic             opnd_clr  [N_OPND];
    logic             opnd_inv  [N_OPND];
    logic [WIDTH-1:0] func_out;

    always_comb begin
        ctl         = alu_op_t'(op);
        opnd_in[0]  = x;
        opnd_in[1]  = y;
        opnd_clr[0] = ctl.zero_x;   // R1
        opnd_inv[0] = ctl.inv_x;
        opnd_clr[1] = ctl.zero_y;   // R2
        opnd_inv[1] = ctl.inv_y;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        alu6_cond #(.WIDTH(WIDTH)) u_cond (
            .din  (opnd_in[g]),
            .clr  (opnd_clr[g]),
            .inv  (opnd_inv[g]),
            .dout (opnd_out[g])
        );
    end

    alu6_func #(.WIDTH(WIDTH)) u_func (
        .a       (opnd_out[0]),
        .b       (opnd_out[1]),
        .sel_add (ctl.sel_add),     // R3
        .inv_out (ctl.inv_out),     // R4
        .y       (func_out)
    );

    alu6_flags #(.WIDTH(WIDTH)) u_flags (
        .val     (func_out),
        .is_zero (zr),              // R6
        .is_neg  (ng)
    );

    assign res = func_out;
endmodule

// File: rtl/alu6_checker.sv
module alu6_checker #(
    parameter int unsigned WIDTH = 16
) (
    input logic [5:0]       op,
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic [WIDTH-1:0] res,
    input logic             zr,
    input logic             ng
);
    always_comb begin
        // R6: zero flag agrees with the result port
        p_zero_flag_r6: assert (zr == (res == '0))
            else $error("zr disagrees with res");

        // R6: sign flag agrees with the result port
        p_sign_flag_r6: assert (ng == res[WIDTH-1])
            else $error("ng disagrees with res");

        // R3: AND with a cleared, uninverted X and no output inversion is zero
        if (op[5] && !op[4] && !op[1] && !op[0]) begin
            p_and_cleared_r3: assert (res == '0)
                else $error("AND with zero X not zero");
        end

        // R1: cleared then inverted X plus cleared Y gives all ones
        if (op == 6'b111010) begin
            p_all_ones_r1: assert (res == '1)
                else $error("minus-one code wrong");
        end

        // R7: code 001100 passes X through
        if (op == 6'b001100) begin
            p_pass_x_r7: assert (res == x)
                else $error("pass-X code wrong");
        end

        // R7: code 110000 passes Y through
        if (op == 6'b110000) begin
            p_pass_y_r7: assert (res == y)
                else $error("pass-Y code wrong");
        end
    end
endmodule

bind alu6_core alu6_checker #(.WIDTH(WIDTH)) u_chk (
    .op  (op),
    .x   (x),
    .y   (y),
    .res (res),
    .zr  (zr),
    .ng  (ng)
);

// File: tb/sim_alu6_core.sv
`timescale 1ns/1ps
module sim_alu6_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op;
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] res;
    logic        zr;
    logic        ng;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    alu6_core u0 (
        .op  (op),
        .x   (x),
        .y   (y),
        .res (res),
        .zr  (zr),
        .ng  (ng)
    );

    // Reference model of the 18 standard codes (R7), computed arithmetically.
    function automatic logic [15:0] model(input logic [5:0] c, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r;
        case (c)
            6'b101010: r = 16'd0;
            6'b111111: r = 16'd1;
            6'b111010: r = 16'hFFFF;
            6'b001100: r = a;
            6'b110000: r = b;
            6'b001101: r = ~a;
            6'b110001: r = ~b;
            6'b001111: r = 16'(0 - int'(a));
            6'b110011: r = 16'(0 - int'(b));
            6'b011111: r = 16'(int'(a) + 1);
            6'b110111: r = 16'(int'(b) + 1);
            6'b001110: r = 16'(int'(a) - 1);
            6'b110010: r = 16'(int'(b) - 1);
            6'b000010: r = 16'(int'(a) + int'(b));
            6'b010011: r = 16'(int'(a) - int'(b));
            6'b000111: r = 16'(int'(b) - int'(a));
            6'b000000: r = a & b;
            6'b010101: r = a | b;
            default:   r = 16'hxxxx;
        endcase
        return r;
    endfunction

    // Drive after a rising edge; results are due combinationally (R8),
    // sampled at the next falling edge.
    task automatic apply(input logic [5:0] c, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] exp_r,
                         input string tag);
        logic exp_z;
        logic exp_n;
        @(posedge clk);
        #0.5;
        op = c;
        x  = a;
        y  = b;
        @(negedge clk);
        exp_z = (exp_r == 16'd0);
        exp_n = exp_r[15];
        n_vec++;
        if (res !== exp_r || zr !== exp_z || ng !== exp_n) begin
            n_fail++;
            $display("FAIL %s op=%b x=%h y=%h : res=%h zr=%b ng=%b expected res=%h zr=%b ng=%b",
                     tag, c, a, b, res, zr, ng, exp_r, exp_z, exp_n);
        end
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                n_vec++;
                n_fail++;
                $display("FAIL watchdog expired (R8) actual=hung expected=done");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [5:0] codes [18];
        codes = '{6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
                  6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
                  6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};
        op = 6'b101010;
        x  = 16'h1234;
        y  = 16'h5678;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Initial state: the zero-constant code gives 0 with zr set
        apply(6'b101010, 16'h1234, 16'h5678, 16'h0000, "R7 zero constant at start");

        // R5 worked examples
        apply(6'b000010, 16'd3, 16'd5, 16'd8, "R5 add 3+5");
        apply(6'b110111, 16'h9999, 16'd5, 16'd6, "R5 Y+1 with Y=5");

        // R1: clear then invert X, AND with Y passes Y
        apply(6'b110000, 16'hABCD, 16'h0F0F, 16'h0F0F, "R1 cleared inverted X ANDed with Y");
        apply(6'b011000, 16'hAAAA, 16'h5555, 16'h0000, "R1 inverted X unaffected cleared Y");

        // R2: clear then invert Y
        apply(6'b001100, 16'hC3C3, 16'h0000, 16'hC3C3, "R2 cleared inverted Y ANDed with X");

        // R3: carry out dropped, AND path
        apply(6'b000010, 16'hFFFF, 16'h0001, 16'h0000, "R3 carry dropped");
        apply(6'b000010, 16'h8000, 16'h8000, 16'h0000, "R3 top carry dropped");
        apply(6'b000000, 16'hF0F0, 16'h3C3C, 16'h3030, "R3 AND path");

        // R4: output inversion
        apply(6'b000001, 16'hF0F0, 16'h3C3C, 16'hCFCF, "R4 inverted AND");

        // R6: flag boundaries
        apply(6'b001100, 16'h8000, 16'h0000, 16'h8000, "R6 sign set");
        apply(6'b001100, 16'h7FFF, 16'h0000, 16'h7FFF, "R6 sign clear");
        apply(6'b010011, 16'd7, 16'd7, 16'h0000, "R6 zero from subtract");
        apply(6'b010011, 16'd0, 16'd1, 16'hFFFF, "R6 negative from subtract");

        // R7 / R8: every standard code on fixed and random operands
        for (int k = 0; k < 18; k++) begin
            apply(codes[k], 16'h0000, 16'hFFFF, model(codes[k], 16'h0000, 16'hFFFF), "R7 code edge");
            apply(codes[k], 16'h7FFF, 16'h8000, model(codes[k], 16'h7FFF, 16'h8000), "R7 code edge");
            for (int n = 0; n < 40; n++) begin
                logic [15:0] ra;
                logic [15:0] rb;
                ra = 16'($urandom);
                rb = 16'($urandom);
                apply(codes[k], ra, rb, model(codes[k], ra, rb), "R7 R8 random operands");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule